// File: doc/BRIEF.md
# Protection Entry Configuration Write Controller

This block owns the register state of a small table of memory protection entries. Each entry has one configuration byte and one address register. A single security configuration register sits beside the table. Software writes reach the block as a plain write strobe, a target selector, an entry index and a data word. For each write the block decides whether the write takes effect, or whether it is a silent no-op or a rejected attempt. It then updates the registers on the next clock edge.

Each accepted write produces one-cycle pulses. One pulse per entry shows which entry's rule must be rebuilt. Another pulse asks for a translation flush. A third pulse flags a rejected write. Address range decoding and permission checking belong to downstream logic that consumes the stored values. All pins are control or status pins, so there is no back-pressure. A write is taken in the cycle in which `wr_en` is high.

Entry locking can be bypassed through a bit in the security register. While the security register's lockdown bit is set, some configuration encodings are refused. When the enhanced feature input is high, the lockdown and whitelist bits become sticky.

Top module: `pmp_cfg_ctrl`

## Requirements
- R1: After reset every configuration byte, every address register and the security register read zero, and all pulse outputs are low.
- R2: An accepted configuration write stores the low data byte at the indexed entry on the next edge and pulses `rule_upd[idx]` for one cycle without a flush request. Configuration byte fields: bit 7 lock, bits 4:3 match mode (00 off, 01 top-of-range), bit 2 execute, bit 1 write, bit 0 read.
- R3: A configuration or address write whose data equals the stored value changes nothing and raises no pulse, even when the entry is locked.
- R4: An entry is read-only when its lock bit is set and the bypass bit (security bit 2) is clear. Configuration and address writes to a read-only entry are ignored and pulse `wr_reject`. With the bypass bit set, locked entries accept writes.
- R5: When the lockdown bit (security bit 0) is set and the bypass bit is clear, a configuration write is rejected if its code {bit7, bit0, bit1, bit2} (MSB first) is 9, 10, 11 or 13. All other codes, and all codes outside that condition, are accepted.
- R6: An address write to entry i below the top is rejected when entry i+1 is read-only and in top-of-range mode. A locked neighbour in off mode does not block the write, and the top entry has no neighbour check.
- R7: An accepted address write stores the data, pulses `rule_upd[i]` and also `rule_upd[i+1]` when entry i+1 is in top-of-range mode, and pulses `flush_req`.
- R8: With `enh_en` high, a security write cannot clear the lockdown bit (bit 0) or the whitelist bit (bit 1) once set, while the bypass bit follows the written data.
- R9: With `enh_en` low, a security write forces bits 0, 1 and 2 to zero.
- R10: A security write is never rejected. It pulses `flush_req` exactly when bit 0 or bit 1 changes value.
- R11: Every pulse output is high for exactly one cycle after the accepted or rejected write and low in a cycle that follows no write. Selector encoding: 0 configuration, 1 address, 2 security, 3 no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_en | input | 1 | Enhanced protection feature enable |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target: 0 config, 1 address, 2 security |
| wr_idx | input | IDX_W (3) | Entry index |
| wr_data | input | ADDR_W (32) | Write data |
| cfg_o | output | N_ENTRY*8 (64) | Configuration bytes, entry 0 in the low byte |
| addr_o | output | N_ENTRY*ADDR_W (256) | Address registers, entry 0 lowest |
| sec_o | output | 3 | Security register {bypass, whitelist, lockdown} |
| rule_upd | output | N_ENTRY (8) | One-cycle rule rebuild pulse per entry |
| flush_req | output | 1 | One-cycle flush request |
| wr_reject | output | 1 | One-cycle rejected-write flag |

## Verification
The hardest state to reach combines a locked top-of-range neighbour with a cleared bypass bit after earlier writes under an active bypass. Because the lockdown and whitelist bits are sticky, the only way back to a permissive register is to drop `enh_en`. So the stimulus is one ordered script. It sets locks, then enables the bypass and edits locked entries. It sets lockdown and probes each forbidden code, toggles the bypass again, and only then turns the feature off to clear the sticky bits. Each step reads the targeted register back through the outputs in the cycle after the write.

// File: rtl/pmp_wr_pkg.sv
package pmp_wr_pkg;
  localparam int CFG_W   = 8;
  localparam int SEC_W   = 3;
  localparam int B_LOCK  = 7;
  localparam int B_EXEC  = 2;
  localparam int B_WRITE = 1;
  localparam int B_READ  = 0;
  localparam int MODE_LO = 3;
  localparam int S_LOCKDN = 0;
  localparam int S_WLIST  = 1;
  localparam int S_BYPASS = 2;
  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_TOR = 2'b01;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  function automatic logic [3:0] perm_code(input logic [CFG_W-1:0] c);
    return {c[B_LOCK], c[B_READ], c[B_WRITE], c[B_EXEC]};
  endfunction

  function automatic logic code_forbidden(input logic [3:0] op);
    case (op)
      4'd9, 4'd10, 4'd11, 4'd13: return 1'b1;
      default:                   return 1'b0;
    endcase
  endfunction

  function automatic logic mode_is_tor(input logic [CFG_W-1:0] c);
    return c[MODE_LO+1:MODE_LO] == MODE_TOR;
  endfunction
endpackage

// File: rtl/pmp_wr_decide.sv
module pmp_wr_decide
  import pmp_wr_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic                          wr_en,
  input  logic [1:0]                    wr_sel,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [ADDR_W-1:0]             wr_data,
  input  logic [N_ENTRY-1:0][CFG_W-1:0] cfg_q,
  input  logic [N_ENTRY-1:0][ADDR_W-1:0] addr_q,
  input  logic                          bypass,
  input  logic                          lockdown,
  output logic [N_ENTRY-1:0]            cfg_we,
  output logic [N_ENTRY-1:0]            addr_we,
  output logic [N_ENTRY-1:0]            upd,
  output logic                          addr_flush,
  output logic                          reject
);
  logic [N_ENTRY-1:0] ro;
  logic [N_ENTRY-1:0] nbr_block;
  logic [N_ENTRY-1:0] nbr_tor;
  logic               in_range;

  generate
    for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
      assign ro[i] = cfg_q[i][B_LOCK] & ~bypass;
      if (i < N_ENTRY - 1) begin : g_nbr
        assign nbr_tor[i]   = mode_is_tor(cfg_q[i+1]);
        assign nbr_block[i] = ro[i+1] & mode_is_tor(cfg_q[i+1]);
      end else begin : g_top
        assign nbr_tor[i]   = 1'b0;
        assign nbr_block[i] = 1'b0;
      end
    end
  endgenerate

  assign in_range = 32'(wr_idx) < N_ENTRY;

  always_comb begin
    cfg_we  = '0;
    addr_we = '0;
    reject  = 1'b0;
    if (wr_en && in_range) begin
      case (wr_sel_e'(wr_sel))
        SEL_CFG: begin
          if (wr_data[CFG_W-1:0] != cfg_q[wr_idx]) begin
            if (ro[wr_idx])
              reject = 1'b1;
            else if (lockdown && !bypass && code_forbidden(perm_code(wr_data[CFG_W-1:0])))
              reject = 1'b1;
            else
              cfg_we[wr_idx] = 1'b1;
          end
        end
        SEL_ADDR: begin
          if (wr_data != addr_q[wr_idx]) begin
            if (nbr_block[wr_idx] || ro[wr_idx])
              reject = 1'b1;
            else
              addr_we[wr_idx] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < N_ENTRY; i++) begin : g_upd
      if (i == 0) begin : g_first
        assign upd[i] = cfg_we[i] | addr_we[i];
      end else begin : g_rest
        assign upd[i] = cfg_we[i] | addr_we[i] | (addr_we[i-1] & nbr_tor[i-1]);
      end
    end
  endgenerate

  assign addr_flush = |addr_we;
endmodule

// File: rtl/pmp_entry_bank.sv
module pmp_entry_bank
  import pmp_wr_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int ADDR_W  = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_ENTRY-1:0]             cfg_we,
  input  logic [N_ENTRY-1:0]             addr_we,
  input  logic [ADDR_W-1:0]              wr_data,
  input  logic                           bypass,
  output logic [N_ENTRY-1:0][CFG_W-1:0]  cfg_q,
  output logic [N_ENTRY-1:0][ADDR_W-1:0] addr_q
);
  generate
    for (genvar i = 0; i < N_ENTRY; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q[i]  <= '0;
          addr_q[i] <= '0;
        end else begin
          if (cfg_we[i])  cfg_q[i]  <= wr_data[CFG_W-1:0];
          if (addr_we[i]) addr_q[i] <= wr_data;
        end
      end

      AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[i][B_LOCK] && !bypass) |=> $stable(cfg_q[i]))
        else $error("locked cfg changed"); // R4
      AST_LOCKED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[i][B_LOCK] && !bypass) |=> $stable(addr_q[i]))
        else $error("locked addr changed"); // R4
    end
  endgenerate
endmodule

// File: rtl/pmp_seccfg_reg.sv
module pmp_seccfg_reg
  import pmp_wr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             enh_en,
  input  logic [SEC_W-1:0] wr_data,
  output logic [SEC_W-1:0] sec_q,
  output logic             chg
);
  logic [SEC_W-1:0] nxt;
  logic [SEC_W-1:0] sticky_mask;

  assign sticky_mask = SEC_W'((1 << S_LOCKDN) | (1 << S_WLIST));
  assign nxt = enh_en ? (wr_data | (sec_q & sticky_mask)) : '0;
  assign chg = wr && ((nxt[S_LOCKDN] != sec_q[S_LOCKDN]) || (nxt[S_WLIST] != sec_q[S_WLIST]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sec_q <= '0;
    else if (wr) sec_q <= nxt;
  end

  AST_LOCKDN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && sec_q[S_LOCKDN]) |=> sec_q[S_LOCKDN])
    else $error("lockdown cleared"); // R8
  AST_WLIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && sec_q[S_WLIST]) |=> sec_q[S_WLIST])
    else $error("whitelist cleared"); // R8
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !enh_en) |=> (sec_q == '0))
    else $error("security bits survived disabled write"); // R9
endmodule

// File: rtl/pmp_cfg_ctrl.sv
module pmp_cfg_ctrl
  import pmp_wr_pkg::*;
#(
  parameter int N_ENTRY = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enh_en,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_sel,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [ADDR_W-1:0]           wr_data,
  output logic [N_ENTRY*CFG_W-1:0]    cfg_o,
  output logic [N_ENTRY*ADDR_W-1:0]   addr_o,
  output logic [SEC_W-1:0]            sec_o,
  output logic [N_ENTRY-1:0]          rule_upd,
  output logic                        flush_req,
  output logic                        wr_reject
);
  logic [N_ENTRY-1:0][CFG_W-1:0]  cfg_q;
  logic [N_ENTRY-1:0][ADDR_W-1:0] addr_q;
  logic [SEC_W-1:0]               sec_q;
  logic [N_ENTRY-1:0]             cfg_we, addr_we, upd;
  logic                           addr_flush, reject, sec_chg, sec_wr;

  assign sec_wr = wr_en && (wr_sel_e'(wr_sel) == SEL_SEC);

  pmp_wr_decide #(.N_ENTRY(N_ENTRY), .ADDR_W(ADDR_W)) u_decide (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
    .cfg_q(cfg_q), .addr_q(addr_q),
    .bypass(sec_q[S_BYPASS]), .lockdown(sec_q[S_LOCKDN]),
    .cfg_we(cfg_we), .addr_we(addr_we), .upd(upd),
    .addr_flush(addr_flush), .reject(reject)
  );

  pmp_entry_bank #(.N_ENTRY(N_ENTRY), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .addr_we(addr_we),
    .wr_data(wr_data), .bypass(sec_q[S_BYPASS]),
    .cfg_q(cfg_q), .addr_q(addr_q)
  );

  pmp_seccfg_reg u_sec (
    .clk(clk), .rst_n(rst_n), .wr(sec_wr), .enh_en(enh_en),
    .wr_data(wr_data[SEC_W-1:0]), .sec_q(sec_q), .chg(sec_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rule_upd  <= '0;
      flush_req <= 1'b0;
      wr_reject <= 1'b0;
    end else begin
      rule_upd  <= upd;
      flush_req <= addr_flush | sec_chg;
      wr_reject <= reject;
    end
  end

  assign cfg_o  = cfg_q;
  assign addr_o = addr_q;
  assign sec_o  = sec_q;

  AST_REJECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> (rule_upd == '0 && !flush_req))
    else $error("reject with update"); // R4
  AST_UPD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rule_upd) <= 2)
    else $error("too many rule updates"); // R7
  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (rule_upd == '0 && !flush_req && !wr_reject))
    else $error("pulse without write"); // R11
  AST_SEC_NO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> !wr_reject)
    else $error("security write rejected"); // R10
endmodule

// File: tb/pmp_cfg_ctrl_bench.sv
module pmp_cfg_ctrl_bench;
  localparam int N  = 8;
  localparam int AW = 32;

  typedef struct packed {
    logic        enh;
    logic [1:0]  sel;
    logic [2:0]  idx;
    logic [31:0] data;
    logic [7:0]  upd;
    logic        flush;
    logic        rej;
    logic [31:0] rb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 3'd0, 32'h03,  8'h01, 1'b0, 1'b0, 32'h03,  4'd2},  // R2
    '{1'b1, 2'd0, 3'd0, 32'h03,  8'h00, 1'b0, 1'b0, 32'h03,  4'd3},  // R3
    '{1'b1, 2'd1, 3'd0, 32'h100, 8'h01, 1'b1, 1'b0, 32'h100, 4'd7},  // R7
    '{1'b1, 2'd0, 3'd1, 32'h89,  8'h02, 1'b0, 1'b0, 32'h89,  4'd2},  // R2
    '{1'b1, 2'd1, 3'd0, 32'h200, 8'h00, 1'b0, 1'b1, 32'h100, 4'd6},  // R6
    '{1'b1, 2'd1, 3'd1, 32'h300, 8'h00, 1'b0, 1'b1, 32'h0,   4'd4},  // R4
    '{1'b1, 2'd0, 3'd1, 32'h00,  8'h00, 1'b0, 1'b1, 32'h89,  4'd4},  // R4
    '{1'b1, 2'd0, 3'd1, 32'h89,  8'h00, 1'b0, 1'b0, 32'h89,  4'd3},  // R3
    '{1'b1, 2'd2, 3'd0, 32'h4,   8'h00, 1'b0, 1'b0, 32'h4,   4'd10}, // R10
    '{1'b1, 2'd1, 3'd0, 32'h200, 8'h03, 1'b1, 1'b0, 32'h200, 4'd7},  // R7
    '{1'b1, 2'd0, 3'd1, 32'h09,  8'h02, 1'b0, 1'b0, 32'h09,  4'd4},  // R4
    '{1'b1, 2'd2, 3'd0, 32'h1,   8'h00, 1'b1, 1'b0, 32'h1,   4'd10}, // R10
    '{1'b1, 2'd2, 3'd0, 32'h0,   8'h00, 1'b0, 1'b0, 32'h1,   4'd8},  // R8
    '{1'b1, 2'd0, 3'd2, 32'h84,  8'h00, 1'b0, 1'b1, 32'h0,   4'd5},  // R5
    '{1'b1, 2'd0, 3'd2, 32'h85,  8'h00, 1'b0, 1'b1, 32'h0,   4'd5},  // R5
    '{1'b1, 2'd0, 3'd2, 32'h86,  8'h00, 1'b0, 1'b1, 32'h0,   4'd5},  // R5
    '{1'b1, 2'd0, 3'd2, 32'h82,  8'h00, 1'b0, 1'b1, 32'h0,   4'd5},  // R5
    '{1'b1, 2'd0, 3'd2, 32'h87,  8'h04, 1'b0, 1'b0, 32'h87,  4'd5},  // R5
    '{1'b1, 2'd0, 3'd3, 32'h04,  8'h08, 1'b0, 1'b0, 32'h04,  4'd5},  // R5
    '{1'b1, 2'd0, 3'd6, 32'h81,  8'h40, 1'b0, 1'b0, 32'h81,  4'd5},  // R5
    '{1'b1, 2'd2, 3'd0, 32'h6,   8'h00, 1'b1, 1'b0, 32'h7,   4'd8},  // R8
    '{1'b1, 2'd2, 3'd0, 32'h0,   8'h00, 1'b0, 1'b0, 32'h3,   4'd8},  // R8
    '{1'b1, 2'd2, 3'd0, 32'h4,   8'h00, 1'b0, 1'b0, 32'h7,   4'd8},  // R8
    '{1'b1, 2'd0, 3'd4, 32'h84,  8'h10, 1'b0, 1'b0, 32'h84,  4'd5},  // R5
    '{1'b1, 2'd0, 3'd2, 32'h00,  8'h04, 1'b0, 1'b0, 32'h00,  4'd4},  // R4
    '{1'b1, 2'd0, 3'd0, 32'h89,  8'h01, 1'b0, 1'b0, 32'h89,  4'd2},  // R2
    '{1'b1, 2'd2, 3'd0, 32'h0,   8'h00, 1'b0, 1'b0, 32'h3,   4'd8},  // R8
    '{1'b1, 2'd1, 3'd7, 32'hABC, 8'h80, 1'b1, 1'b0, 32'hABC, 4'd6},  // R6
    '{1'b0, 2'd2, 3'd0, 32'h7,   8'h00, 1'b1, 1'b0, 32'h0,   4'd9},  // R9
    '{1'b0, 2'd2, 3'd0, 32'h7,   8'h00, 1'b0, 1'b0, 32'h0,   4'd9},  // R9
    '{1'b0, 2'd0, 3'd5, 32'h84,  8'h20, 1'b0, 1'b0, 32'h84,  4'd5},  // R5
    '{1'b0, 2'd0, 3'd5, 32'h00,  8'h00, 1'b0, 1'b1, 32'h84,  4'd4},  // R4
    '{1'b0, 2'd1, 3'd3, 32'h55,  8'h08, 1'b1, 1'b0, 32'h55,  4'd6},  // R6
    '{1'b0, 2'd1, 3'd0, 32'h200, 8'h00, 1'b0, 1'b0, 32'h200, 4'd3}   // R3
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enh_en = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [2:0]    wr_idx = '0;
  logic [AW-1:0] wr_data = '0;
  logic [N*8-1:0]  cfg_o;
  logic [N*AW-1:0] addr_o;
  logic [2:0]      sec_o;
  logic [N-1:0]    rule_upd;
  logic            flush_req, wr_reject;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmp_cfg_ctrl #(.N_ENTRY(N), .ADDR_W(AW)) u_pmp_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_data(wr_data), .cfg_o(cfg_o), .addr_o(addr_o),
    .sec_o(sec_o), .rule_upd(rule_upd), .flush_req(flush_req), .wr_reject(wr_reject)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] readback(input logic [1:0] sel, input logic [2:0] idx);
    case (sel)
      2'd0:    return {24'b0, cfg_o[idx*8 +: 8]};
      2'd1:    return addr_o[idx*AW +: AW];
      default: return {29'b0, sec_o};
    endcase
  endfunction

  task automatic check_idle_state(input string req);
    chk(req, "cfg all", cfg_o[31:0] | cfg_o[63:32], 32'h0);
    chk(req, "addr or", 32'(|addr_o), 32'h0);
    chk(req, "sec", {29'b0, sec_o}, 32'h0);
    chk(req, "pulses", {22'b0, rule_upd, flush_req, wr_reject}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check_idle_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle_state("R1");

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VECS[k].req, k);
      enh_en  = VECS[k].enh;
      wr_sel  = VECS[k].sel;
      wr_idx  = VECS[k].idx;
      wr_data = VECS[k].data;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk(tag, "rule_upd", {24'b0, rule_upd}, {24'b0, VECS[k].upd});
      chk(tag, "flush_req", {31'b0, flush_req}, {31'b0, VECS[k].flush});
      chk(tag, "wr_reject", {31'b0, wr_reject}, {31'b0, VECS[k].rej});
      chk(tag, "readback", readback(VECS[k].sel, VECS[k].idx), VECS[k].rb);
      @(negedge clk);
      chk("R11", "pulses after one cycle", {22'b0, rule_upd, flush_req, wr_reject}, 32'h0);
    end

    // R11: selector 3 leaves everything untouched and pulses nothing
    wr_sel = 2'd3; wr_idx = 3'd1; wr_data = 32'hFF; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11", "sel3 pulses", {22'b0, rule_upd, flush_req, wr_reject}, 32'h0);
    chk("R11", "sel3 cfg1", readback(2'd0, 3'd1), 32'h09);

    // R6: entry 0 is locked TOR; entry 7 write earlier did not pulse entry 0
    chk("R6", "entry0 cfg kept", readback(2'd0, 3'd0), 32'h89);

    // R1: reset in mid-run returns everything to zero
    rst_n = 1'b0;
    @(negedge clk);
    check_idle_state("R1");
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule